// File: doc/BRIEF.md
# Byte Increment Execution Unit

This unit executes the single-operand increment instruction of a small 8-bit microcontroller core. It decodes the 16-bit instruction word. It drives the register-file read address straight from the register field, and it takes the byte read back from that address. It registers three results: the byte plus one, the index of the register to write, and a new status byte.

Only the increment opcode is recognised. On a match the unit raises a match flag, a write enable and a program-counter advance request. On any other word, write-back stays off and the status byte passes through unchanged.

The arithmetic flags follow the increment's own rules. Carry is never touched, so the unit can step a loop counter inside multi-byte arithmetic. Overflow marks only the 0x7F to 0x80 step. All results appear one clock after the inputs are presented.

Top module: `inc_unit`

## Requirements
- R1: `match_o` rises one clock after an instruction word with `(instr & 16'hFE0F) == 16'h9403`, and stays low for any other word.
- R2: On a match, `wb_en_o` is 1, `wb_idx_o` is instruction bits [8:4], and `wb_data_o` is the read byte plus one modulo 256 (0xFF becomes 0x00).
- R3: Status bit 0 (carry) of `sreg_o` always equals bit 0 of the `sreg_i` presented one clock earlier.
- R4: On a match, status bit 3 (overflow) is 1 exactly when the read byte was 0x7F.
- R5: On a match, status bit 2 (negative) equals bit 7 of the result, and status bit 1 (zero) is 1 exactly when the result is 0x00.
- R6: On a match, status bit 4 (sign) equals bit 2 XOR bit 3 of the new status, and bits 7, 6 and 5 are copied from `sreg_i`.
- R7: On no match, `wb_en_o`, `wb_idx_o`, `wb_data_o` and `pc_adv_o` are 0, and `sreg_o` equals the previous `sreg_i`.
- R8: On a match, `pc_adv_o` is 1, requesting a one-word program-counter step.
- R9: `rf_raddr_o` equals instruction bits [8:4] in the same cycle, with no register in the path.
- R10: While `rst_n` is low, and in the first cycle after reset is released, every registered output reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word |
| rf_raddr_o | output | 5 | Register-file read address |
| rf_rdata_i | input | 8 | Byte read from that address |
| sreg_i | input | 8 | Current status byte (I,T,H,S,V,N,Z,C from bit 7 to bit 0) |
| match_o | output | 1 | Increment opcode was seen |
| wb_en_o | output | 1 | Write-back enable |
| wb_idx_o | output | 5 | Write-back register index |
| wb_data_o | output | 8 | Write-back value |
| sreg_o | output | 8 | Updated status byte |
| pc_adv_o | output | 1 | Program-counter one-word step request |

## Verification
On every cycle the assertions check the relations between status bits: carry is passed through, the sign flag is the XOR of the negative and overflow flags, and the overflow, negative and zero flags agree with the registered result. They also check that a matched word yields the incremented byte one clock later, and that any other word leaves write-back off and copies the status byte. Only the bench scenarios can show certain things. These are the exact encoding boundaries that separate the increment from its neighbouring opcodes, the extreme register indices 0 and 31, the wrap of 0xFF to 0x00, the same-cycle read address, and the cleared outputs after a reset in the middle of a run.

// File: rtl/inc_pkg.sv
package inc_pkg;

    localparam int DATA_W  = 8;
    localparam int IDX_W   = 5;
    localparam int INSTR_W = 16;

    // status byte bit positions
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_S = 4;

    // register field location inside the instruction word
    localparam int IDX_LSB = 4;

    typedef struct packed {
        logic              match;
        logic              wb_en;
        logic [IDX_W-1:0]  wb_idx;
        logic [DATA_W-1:0] wb_data;
        logic [DATA_W-1:0] sreg;
        logic              pc_adv;
    } inc_state_t;

endpackage

// File: rtl/inc_decode.sv
module inc_decode
    import inc_pkg::*;
#(
    parameter logic [INSTR_W-1:0] OP_MASK    = 16'hFE0F,
    parameter logic [INSTR_W-1:0] OP_PATTERN = 16'h9403
) (
    input  logic [INSTR_W-1:0] instr_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);

    localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

    always_comb begin
        hit_o = ((instr_i & OP_MASK) == OP_PATTERN);
        idx_o = instr_i[IDX_MSB:IDX_LSB];
    end

endmodule

// File: rtl/inc_flags.sv
module inc_flags
    import inc_pkg::*;
(
    input  logic [DATA_W-1:0] operand_i,
    input  logic [DATA_W-1:0] sreg_i,
    output logic [DATA_W-1:0] result_o,
    output logic [DATA_W-1:0] sreg_o
);

    // largest positive two's complement value: 0111...1
    localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};

    logic ovf;
    logic neg;
    logic zer;

    always_comb begin
        result_o = operand_i + DATA_W'(1);
        ovf      = (operand_i == MAX_POS);
        neg      = result_o[DATA_W-1];
        zer      = ~(|result_o);

        sreg_o        = sreg_i;
        sreg_o[FLG_V] = ovf;
        sreg_o[FLG_N] = neg;
        sreg_o[FLG_Z] = zer;
        sreg_o[FLG_S] = neg ^ ovf;
    end

endmodule

// File: rtl/inc_unit.sv
module inc_unit
    import inc_pkg::*;
#(
    parameter logic [INSTR_W-1:0] OP_MASK    = 16'hFE0F,
    parameter logic [INSTR_W-1:0] OP_PATTERN = 16'h9403
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    output logic [IDX_W-1:0]   rf_raddr_o,
    input  logic [DATA_W-1:0]  rf_rdata_i,
    input  logic [DATA_W-1:0]  sreg_i,
    output logic               match_o,
    output logic               wb_en_o,
    output logic [IDX_W-1:0]   wb_idx_o,
    output logic [DATA_W-1:0]  wb_data_o,
    output logic [DATA_W-1:0]  sreg_o,
    output logic               pc_adv_o
);

    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] sreg_new;

    inc_state_t st_d;
    inc_state_t st_q;

    inc_decode #(
        .OP_MASK    (OP_MASK),
        .OP_PATTERN (OP_PATTERN)
    ) u_decode (
        .instr_i (instr_i),
        .hit_o   (hit),
        .idx_o   (idx)
    );

    inc_flags u_flags (
        .operand_i (rf_rdata_i),
        .sreg_i    (sreg_i),
        .result_o  (sum),
        .sreg_o    (sreg_new)
    );

    assign rf_raddr_o = idx;

    always_comb begin
        st_d = '0;
        st_d.match = hit;
        if (hit) begin
            st_d.wb_en   = 1'b1;
            st_d.wb_idx  = idx;
            st_d.wb_data = sum;
            st_d.sreg    = sreg_new;
            st_d.pc_adv  = 1'b1;
        end else begin
            st_d.sreg    = sreg_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match_o   = st_q.match;
    assign wb_en_o   = st_q.wb_en;
    assign wb_idx_o  = st_q.wb_idx;
    assign wb_data_o = st_q.wb_data;
    assign sreg_o    = st_q.sreg;
    assign pc_adv_o  = st_q.pc_adv;

endmodule

// File: rtl/inc_unit_chk.sv
module inc_unit_chk
    import inc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr_i,
    input logic [DATA_W-1:0]  rf_rdata_i,
    input logic [DATA_W-1:0]  sreg_i,
    input logic               match_o,
    input logic               wb_en_o,
    input logic [DATA_W-1:0]  wb_data_o,
    input logic [DATA_W-1:0]  sreg_o,
    input logic               pc_adv_o
);

    logic is_inc;
    assign is_inc = ((instr_i & 16'hFE0F) == 16'h9403);

    // R1
    inc_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_inc |=> match_o);

    // R2
    inc_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_inc |=> (wb_en_o && wb_data_o == 8'($past(rf_rdata_i) + 8'd1)));

    // R3
    carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sreg_o[FLG_C] == $past(sreg_i[FLG_C])));

    // R4
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (sreg_o[FLG_V] == (wb_data_o == 8'h80)));

    // R5
    nz_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (sreg_o[FLG_N] == wb_data_o[7] &&
                     sreg_o[FLG_Z] == (wb_data_o == 8'h00)));

    // R6
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (sreg_o[FLG_S] == (sreg_o[FLG_N] ^ sreg_o[FLG_V])));

    // R7
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_inc |=> (!wb_en_o && !pc_adv_o && sreg_o == $past(sreg_i)));

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> pc_adv_o);

endmodule

bind inc_unit inc_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_i    (instr_i),
    .rf_rdata_i (rf_rdata_i),
    .sreg_i     (sreg_i),
    .match_o    (match_o),
    .wb_en_o    (wb_en_o),
    .wb_data_o  (wb_data_o),
    .sreg_o     (sreg_o),
    .pc_adv_o   (pc_adv_o)
);

// File: tb/inc_unit_tb.sv
module inc_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr_i = 16'h0000;
    logic [7:0]  rf_rdata_i = 8'h00;
    logic [7:0]  sreg_i = 8'h00;
    logic [4:0]  rf_raddr_o;
    logic        match_o;
    logic        wb_en_o;
    logic [4:0]  wb_idx_o;
    logic [7:0]  wb_data_o;
    logic [7:0]  sreg_o;
    logic        pc_adv_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    inc_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_i    (instr_i),
        .rf_raddr_o (rf_raddr_o),
        .rf_rdata_i (rf_rdata_i),
        .sreg_i     (sreg_i),
        .match_o    (match_o),
        .wb_en_o    (wb_en_o),
        .wb_idx_o   (wb_idx_o),
        .wb_data_o  (wb_data_o),
        .sreg_o     (sreg_o),
        .pc_adv_o   (pc_adv_o)
    );

    localparam int NV = 10;
    // stimulus: instruction, operand, status in
    localparam logic [15:0] V_INS [NV] = '{16'h9403, 16'h95F3, 16'h9453, 16'h9513, 16'h94A3,
                                           16'h9403, 16'h9404, 16'h9C03, 16'h940C, 16'h97F3};
    localparam logic [7:0]  V_OP  [NV] = '{8'h00, 8'h7F, 8'hFF, 8'h80, 8'h7E,
                                           8'h0F, 8'h7F, 8'h7F, 8'h10, 8'h22};
    localparam logic [7:0]  V_SR  [NV] = '{8'h00, 8'h00, 8'h01, 8'hFF, 8'hE1,
                                           8'h1E, 8'h5A, 8'hA5, 8'h3C, 8'h81};
    // expected: match, read address, write data, status out
    localparam logic        E_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                           1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
    localparam logic [4:0]  E_IDX [NV] = '{5'd0, 5'd31, 5'd5, 5'd17, 5'd10,
                                           5'd0, 5'd0, 5'd0, 5'd0, 5'd31};
    localparam logic [7:0]  E_DAT [NV] = '{8'h01, 8'h80, 8'h00, 8'h81, 8'h7F,
                                           8'h10, 8'h00, 8'h00, 8'h00, 8'h00};
    localparam logic [7:0]  E_SR  [NV] = '{8'h00, 8'h0C, 8'h03, 8'hF5, 8'hE1,
                                           8'h00, 8'h5A, 8'hA5, 8'h3C, 8'h81};

    task automatic check(input string req, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R10: outputs held at zero during reset
        repeat (3) @(negedge clk);
        instr_i = 16'h9403; rf_rdata_i = 8'h44; sreg_i = 8'hFF;
        @(negedge clk);
        check("R10", "match in reset", {15'd0, match_o}, 16'd0);
        check("R10", "sreg in reset", {8'd0, sreg_o}, 16'd0);
        check("R10", "wb in reset", {7'd0, wb_en_o, wb_data_o}, 16'd0);
        rst_n = 1'b1;
        instr_i = 16'h0000; sreg_i = 8'h00;
        // R10: outputs still zero right after release
        check("R10", "data after release", {8'd0, wb_data_o}, 16'd0);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            instr_i    = V_INS[i];
            rf_rdata_i = V_OP[i];
            sreg_i     = V_SR[i];
            #1;
            // R9
            check("R9", "read address", {11'd0, rf_raddr_o}, {11'd0, E_IDX[i]});
            @(negedge clk);
            // R1
            check("R1", "match", {15'd0, match_o}, {15'd0, E_HIT[i]});
            // R2 R7
            check(E_HIT[i] ? "R2" : "R7", "write enable", {15'd0, wb_en_o}, {15'd0, E_HIT[i]});
            check(E_HIT[i] ? "R2" : "R7", "write index", {11'd0, wb_idx_o},
                  E_HIT[i] ? {11'd0, E_IDX[i]} : 16'd0);
            check(E_HIT[i] ? "R2" : "R7", "write data", {8'd0, wb_data_o}, {8'd0, E_DAT[i]});
            // R3 R4 R5 R6 R7
            check("R3", "carry", {15'd0, sreg_o[0]}, {15'd0, E_SR[i][0]});
            check(E_HIT[i] ? "R4" : "R7", "overflow", {15'd0, sreg_o[3]}, {15'd0, E_SR[i][3]});
            check(E_HIT[i] ? "R5" : "R7", "neg/zero", {14'd0, sreg_o[2:1]}, {14'd0, E_SR[i][2:1]});
            check(E_HIT[i] ? "R6" : "R7", "status byte", {8'd0, sreg_o}, {8'd0, E_SR[i]});
            // R8
            check("R8", "pc step", {15'd0, pc_adv_o}, {15'd0, E_HIT[i]});
        end

        // back-to-back increments of the same register across a wrap (R2)
        rf_rdata_i = 8'hFE; sreg_i = 8'h00; instr_i = 16'h9473;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R2", "chained data", {8'd0, wb_data_o}, {8'd0, 8'(rf_rdata_i + 8'd1)});
            check("R2", "chained index", {11'd0, wb_idx_o}, 16'd7);
            rf_rdata_i = wb_data_o;
        end

        // R10: reset in the middle of a run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "match after mid reset", {15'd0, match_o}, 16'd0);
        check("R10", "pc after mid reset", {15'd0, pc_adv_o}, 16'd0);
        rst_n = 1'b1;

        @(negedge clk);
        finish_run();
    end

endmodule